// File: doc/BRIEF.md
# Byte-Serial Memory Add and Copy Engine

This block performs a multi-byte addition or copy directly on memory, one byte at a time, through a single synchronous memory port. A controller hands it a source address, a destination address, an operation and a width code, and pulses start. For an add, the engine reads a source byte and the matching destination byte, sums them with the running carry and writes the sum back over the destination byte. For a copy, it reads a source byte and writes it unchanged to the destination. Operands are little-endian: byte 0 sits at the base address and later bytes at ascending addresses.

The engine is meant to run while its host processor is stalled, so it gives only a busy level, a one-cycle done pulse and the final carry. The memory port issues either one read or one write per cycle. Read data must arrive on the cycle after the read is issued. Addresses wrap modulo 2^16.

The controller steps through five states. `ST_IDLE` waits for start. `ST_FETCH_SRC` reads a source byte. `ST_FETCH_DST` captures that byte and reads the destination byte; only an add visits this state. `ST_STORE` writes the result. `ST_FINISH` raises done. The transitions are:
- `ST_IDLE` goes to `ST_FETCH_SRC` on start.
- `ST_FETCH_SRC` goes to `ST_FETCH_DST` for an add and straight to `ST_STORE` for a copy.
- `ST_FETCH_DST` goes to `ST_STORE`.
- `ST_STORE` goes back to `ST_FETCH_SRC` while bytes remain, and to `ST_FINISH` after the last byte.
- `ST_FINISH` goes to `ST_IDLE`.

Top module: `memop_engine`

## Requirements
- R1: While reset is asserted and just after it is released, `busy_o`, `done_o`, `carry_o`, `mem_re_o` and `mem_we_o` are all 0.
- R2: With `op_i`=0 (add), the width code `len_i` of 0, 1, 2 or 3 selects 1, 2, 3 or 4 bytes. The destination operand becomes (dst + src) mod 2^(8·bytes), and no other memory byte changes.
- R3: Bytes are handled least significant first. Each byte is fully processed before the next byte's source is read. Byte k uses addresses base+k modulo 2^16, which wrap past 0xFFFF.
- R4: The carry is cleared when an operation is accepted and passes from each byte to the next. After an add, `carry_o` holds the carry out of the most significant byte and keeps it until the next accepted start.
- R5: With `op_i`=1 (copy), the selected number of bytes is copied from source to destination, and `carry_o` reads 0 afterwards.
- R6: Read and write are never asserted together. Every write comes in the cycle right after a read. An add makes 2n reads and n writes, and a copy makes n reads and n writes.
- R7: Counting the clock edge that samples start as edge 1, `done_o` is high after edge 3n+1 for an add and after edge 2n+1 for a copy, where n is the byte count.
- R8: `done_o` is high for exactly one cycle. `busy_o` is high from the cycle after start through the done cycle, and low in the cycle that follows. No memory access occurs while `busy_o` is low.
- R9: A start that is sampled while `busy_o` is high, including during the done cycle, is ignored. Memory, carry and timing follow the operation in progress only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| op_i | input | 1 | 0 = add source into destination, 1 = copy |
| len_i | input | LEN_W (2) | Width code, byte count minus one |
| src_addr_i | input | ADDR_W (16) | Base address of the source operand |
| dst_addr_i | input | ADDR_W (16) | Base address of the destination operand |
| mem_addr_o | output | ADDR_W (16) | Memory address for the current access |
| mem_re_o | output | 1 | Read strobe; data is expected on the next cycle |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | DATA_W (8) | Write data |
| mem_rdata_i | input | DATA_W (8) | Read data, one cycle after `mem_re_o` |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 1 | Final carry of the last add |

## Verification
The hardest situation to reach from the ports is a start that arrives in the last cycles of an operation, most of all in the done cycle itself, where it must still be ignored. The bench places such a second start at a random cycle index during about a third of its operations, and in some of them it lands on the done cycle. Long carry chains and address wrap are also rare under random data. Directed cases cover them: 0xFFFFFFFF plus one, operands that straddle 0xFFFF, and overlapping copies, which show the byte order.

// File: rtl/memop_pkg.sv
package memop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FETCH_SRC = 3'd1,
        ST_FETCH_DST = 3'd2,
        ST_STORE     = 3'd3,
        ST_FINISH    = 3'd4
    } eng_state_e;

    typedef enum logic {
        OP_ADD  = 1'b0,
        OP_MOVE = 1'b1
    } eng_op_e;

    typedef enum logic {
        SEL_SRC = 1'b0,
        SEL_DST = 1'b1
    } addr_sel_e;

endpackage

// File: rtl/memop_byte_alu.sv
module memop_byte_alu #(
    parameter int DATA_W = 8
) (
    input  logic              op_move_i,
    input  logic [DATA_W-1:0] src_byte_i,
    input  logic [DATA_W-1:0] rd_byte_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);

    logic [DATA_W:0] sum;

    always_comb begin
        sum = {1'b0, src_byte_i} + {1'b0, rd_byte_i} + {{DATA_W{1'b0}}, carry_i};
        if (op_move_i) begin
            // copy: the byte just read is the source byte
            res_o   = rd_byte_i;
            carry_o = 1'b0;
        end else begin
            res_o   = sum[DATA_W-1:0];
            carry_o = sum[DATA_W];
        end
    end

endmodule

// File: rtl/memop_idx_ctr.sv
module memop_idx_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] idx_o,
    output logic             last_o
);

    logic [CNT_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear_i) begin
            idx_q <= '0;
        end else if (step_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == limit_i);

endmodule

// File: rtl/memop_addr_gen.sv
module memop_addr_gen
    import memop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 2
) (
    input  addr_sel_e         sel_i,
    input  logic [ADDR_W-1:0] src_base_i,
    input  logic [ADDR_W-1:0] dst_base_i,
    input  logic [CNT_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int PAD_W = ADDR_W - CNT_W;

    logic [ADDR_W-1:0] offset;

    assign offset = {{PAD_W{1'b0}}, idx_i};

    always_comb begin
        unique case (sel_i)
            SEL_SRC: addr_o = src_base_i + offset;
            SEL_DST: addr_o = dst_base_i + offset;
            default: addr_o = dst_base_i + offset;
        endcase
    end

endmodule

// File: rtl/memop_engine.sv
module memop_engine
    import memop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              carry_o
);

    eng_state_e        state_q, state_d;
    eng_op_e           op_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [DATA_W-1:0] src_byte_q;
    logic              carry_q;

    logic              accept;
    logic              step;
    logic              last;
    logic [LEN_W-1:0]  idx;
    addr_sel_e         addr_sel;
    logic [DATA_W-1:0] alu_res;
    logic              alu_cout;

    assign accept = start_i && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_FETCH_SRC;
            ST_FETCH_SRC: state_d = (op_q == OP_MOVE) ? ST_STORE : ST_FETCH_DST;
            ST_FETCH_DST: state_d = ST_STORE;
            ST_STORE:     state_d = last ? ST_FINISH : ST_FETCH_SRC;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs of the current state
    always_comb begin
        mem_re_o = 1'b0;
        mem_we_o = 1'b0;
        addr_sel = SEL_SRC;
        step     = 1'b0;
        done_o   = 1'b0;
        busy_o   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
            end
            ST_FETCH_SRC: begin
                mem_re_o = 1'b1;
                addr_sel = SEL_SRC;
            end
            ST_FETCH_DST: begin
                mem_re_o = 1'b1;
                addr_sel = SEL_DST;
            end
            ST_STORE: begin
                mem_we_o = 1'b1;
                addr_sel = SEL_DST;
                step     = !last;
            end
            ST_FINISH: begin
                done_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    // operand and carry registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_ADD;
            len_q      <= '0;
            src_q      <= '0;
            dst_q      <= '0;
            src_byte_q <= '0;
            carry_q    <= 1'b0;
        end else begin
            if (accept) begin
                op_q    <= eng_op_e'(op_i);
                len_q   <= len_i;
                src_q   <= src_addr_i;
                dst_q   <= dst_addr_i;
                carry_q <= 1'b0;
            end
            if (state_q == ST_FETCH_DST) begin
                src_byte_q <= mem_rdata_i;
            end
            if (state_q == ST_STORE) begin
                carry_q <= alu_cout;
            end
        end
    end

    memop_idx_ctr #(
        .CNT_W (LEN_W)
    ) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .step_i  (step),
        .limit_i (len_q),
        .idx_o   (idx),
        .last_o  (last)
    );

    memop_addr_gen #(
        .ADDR_W (ADDR_W),
        .CNT_W  (LEN_W)
    ) u_addr (
        .sel_i      (addr_sel),
        .src_base_i (src_q),
        .dst_base_i (dst_q),
        .idx_i      (idx),
        .addr_o     (mem_addr_o)
    );

    memop_byte_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op_move_i  (op_q == OP_MOVE),
        .src_byte_i (src_byte_q),
        .rd_byte_i  (mem_rdata_i),
        .carry_i    (carry_q),
        .res_o      (alu_res),
        .carry_o    (alu_cout)
    );

    assign mem_wdata_o = alu_res;
    assign carry_o     = carry_q;

endmodule

// File: rtl/memop_engine_chk.sv
module memop_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic mem_re_o,
    input logic mem_we_o,
    input logic busy_o,
    input logic done_o,
    input logic carry_o
);

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re_o && mem_we_o)); // R6

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $past(mem_re_o)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R8

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R8

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o); // R8

    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(mem_re_o || mem_we_o)); // R8

    AST_CARRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(carry_o)); // R4

endmodule

bind memop_engine memop_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .mem_re_o (mem_re_o),
    .mem_we_o (mem_we_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .carry_o  (carry_o)
);

// File: tb/memop_engine_tb.sv
`timescale 1ns/1ps
module memop_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic [1:0]  len_i = '0;
    logic [15:0] src_addr_i = '0;
    logic [15:0] dst_addr_i = '0;
    logic [15:0] mem_addr_o;
    logic        mem_re_o;
    logic        mem_we_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i = '0;
    logic        busy_o;
    logic        done_o;
    logic        carry_o;

    int n_chk = 0;
    int n_err = 0;

    logic [7:0] mem     [256];
    logic [7:0] ref_mem [256];

    always #10 clk = ~clk;

    memop_engine u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .op_i        (op_i),
        .len_i       (len_i),
        .src_addr_i  (src_addr_i),
        .dst_addr_i  (dst_addr_i),
        .mem_addr_o  (mem_addr_o),
        .mem_re_o    (mem_re_o),
        .mem_we_o    (mem_we_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .carry_o     (carry_o)
    );

    // synchronous memory model, low 8 address bits
    always @(posedge clk) begin
        if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
        if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
    end

    function automatic logic [8:0] add_byte(input logic [7:0] a, input logic [7:0] b, input logic c);
        return {1'b0, a} + {1'b0, b} + {8'd0, c};
    endfunction

    function automatic int exp_latency(input bit op, input int w);
        return (op ? 2 : 3) * (w + 1) + 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_mem(input string tag);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 256; i++) begin
            if (mem[i] !== ref_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) chk(1'b1, tag, "memory", 0, 0);
        else chk(1'b0, tag, $sformatf("memory byte %0h", first), longint'(mem[first]), longint'(ref_mem[first]));
    endtask

    // one operation; inj_at > 0 places a second start at that cycle index
    task automatic run_op(input bit op, input int w, input logic [15:0] s, input logic [15:0] d,
                          input int inj_at, input string tag);
        logic       c = 1'b0;
        logic [8:0] r;
        int         cyc = 0;
        int         rd_cnt = 0;
        int         wr_cnt = 0;
        int         both = 0;
        bit         busy_bad = 1'b0;
        bit         got_done = 1'b0;
        int         lat = exp_latency(op, w);

        for (int i = 0; i <= w; i++) begin
            logic [7:0] sb = ref_mem[8'(s + 16'(i))];
            logic [7:0] db = ref_mem[8'(d + 16'(i))];
            if (op) begin
                r = {1'b0, sb};
            end else begin
                r = add_byte(sb, db, c);
            end
            c = r[8];
            ref_mem[8'(d + 16'(i))] = r[7:0];
        end

        @(negedge clk);
        start_i = 1'b1; op_i = op; len_i = 2'(w); src_addr_i = s; dst_addr_i = d;
        while (cyc < 64) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start_i = 1'b0;
            rd_cnt += int'(mem_re_o);
            wr_cnt += int'(mem_we_o);
            both   += int'(mem_re_o && mem_we_o);
            if (!busy_o) busy_bad = 1'b1;
            if (cyc == inj_at || (done_o && inj_at >= cyc)) begin
                start_i = 1'b1; op_i = ~op; len_i = ~2'(w);
                src_addr_i = 16'($urandom); dst_addr_i = 16'($urandom);
            end
            if (done_o) begin
                got_done = 1'b1;
                break;
            end
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(got_done && cyc == lat, "R7", "done latency", cyc, lat);
        chk(!busy_bad, "R8", "busy dropped before done", busy_bad, 0);
        chk(!busy_o && !done_o, "R8", "busy/done after done", {busy_o, done_o}, 0);
        chk(both == 0 && wr_cnt == w + 1 && rd_cnt == (op ? 1 : 2) * (w + 1),
            "R6", "reads/writes", rd_cnt * 256 + wr_cnt, (op ? 1 : 2) * (w + 1) * 256 + w + 1);
        compare_mem(tag);
        chk(carry_o === c, op ? "R5" : "R4", "carry", carry_o, c);
    endtask

    task automatic poke4(input logic [15:0] a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) begin
            mem[8'(a + 16'(i))]     = v[8*i +: 8];
            ref_mem[8'(a + 16'(i))] = v[8*i +: 8];
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'($urandom);
            ref_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({busy_o, done_o, carry_o, mem_re_o, mem_we_o} == 5'b0, "R1", "outputs in reset",
            {busy_o, done_o, carry_o, mem_re_o, mem_we_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, done_o, carry_o, mem_re_o, mem_we_o} == 5'b0, "R1", "outputs after reset",
            {busy_o, done_o, carry_o, mem_re_o, mem_we_o}, 0);

        // R4: full 32-bit carry ripple, 0xFFFFFFFF + 1
        poke4(16'h0040, 32'h0000_0001);
        poke4(16'h0050, 32'hFFFF_FFFF);
        run_op(1'b0, 3, 16'h0040, 16'h0050, 0, "R2");
        chk({mem[8'h53], mem[8'h52], mem[8'h51], mem[8'h50]} == 32'h0, "R4", "ripple sum",
            {mem[8'h53], mem[8'h52], mem[8'h51], mem[8'h50]}, 0);
        repeat (4) @(negedge clk);
        chk(carry_o == 1'b1, "R4", "carry held while idle", carry_o, 1);

        // R4: carry cleared at next start; single byte no overflow
        poke4(16'h0060, 32'h0000_0001);
        poke4(16'h0064, 32'h0000_0002);
        run_op(1'b0, 0, 16'h0060, 16'h0064, 0, "R4");
        chk(mem[8'h64] == 8'h03, "R4", "carry not reused", mem[8'h64], 3);

        // R3: operands straddling the top of the address space
        run_op(1'b0, 3, 16'hFFFE, 16'h7FFF, 0, "R3");
        run_op(1'b1, 3, 16'h00FE, 16'hFFFD, 0, "R3");

        // R3: overlapping copy, destination one above source, ripples byte 0
        poke4(16'h0080, 32'h4433_2211);
        run_op(1'b1, 3, 16'h0080, 16'h0081, 0, "R3");
        chk(mem[8'h84] == 8'h11, "R3", "overlap ripple top", mem[8'h84], 8'h11);

        // R9: start in the done cycle and right after start
        run_op(1'b0, 1, 16'h0010, 16'h0020, 99, "R9");
        run_op(1'b1, 2, 16'h0030, 16'h00A0, 1, "R9");

        // random mix
        for (int k = 0; k < 48; k++) begin
            bit op = 1'($urandom);
            int w  = int'($urandom_range(0, 3));
            int inj = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, exp_latency(op, w))) : 0;
            run_op(op, w, 16'($urandom), 16'($urandom), inj,
                   inj != 0 ? "R9" : (op ? "R5" : "R2"));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule